// File: doc/BRIEF.md
# Block Coefficient Dequantizer

This block turns the quantized levels of one 8x8 transform block back into transform coefficients. It takes one level per clock. Each level comes with its position in the block (0 to 63, row-major), a flag that says whether the block is intra coded, and a two-bit code for the precision of the intra DC term. For each level the block returns a 12-bit signed coefficient two clocks later. The position index and a valid flag travel with the result.

Two arithmetic paths produce the result. The DC term of an intra block (position 0) goes through a shift path whose multiplier depends on the precision code. Every other level goes through the AC path. That path multiplies the level by a weighting-matrix entry and by a quantiser scale that is fixed at build time, then divides by 32. Intra and non-intra blocks each have their own weighting matrix. Both matrices start from computed defaults, and software can overwrite single entries through a small write port. Every result is clamped to the 12-bit signed range.

Top module: `blk_dequant`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `out_valid` is 0 and `out_coef` is 0.
- R2: A level accepted with `in_valid`=1 at a clock edge shows up on `out_valid`/`out_index`/`out_coef` after the second edge that follows. `out_index` equals the input index, and `out_valid` is 0 two edges after an edge that had no valid input.
- R3: For `in_intra`=1 and `in_index`=0, the result is level times M, where M is 8, 4, 2 or 1 for `in_dc_prec` = 0, 1, 2 or 3.
- R4: For `in_intra`=1 and `in_index`≠0, the result is (2·L·W·S)/32, where W is the entry at that index of the intra matrix and S = `QSCALE` (default 4).
- R5: For `in_intra`=0 at any index, including 0, the result is ((2·L + sign(L))·W·S)/32, where W is the entry of the non-intra matrix.
- R6: Every division is truncated toward zero, so a negative level gives the negation of the result for its magnitude.
- R7: Every result is clamped to the range −2048 to +2047.
- R8: A level of 0 always produces 0, whatever the block type, index or precision.
- R9: After reset, with index i = 8·row + col, the intra matrix holds 8 + 2·(row+col) and the non-intra matrix holds 16 + (row+col).
- R10: A write with `cfg_we`=1 stores `cfg_wdata` into entry `cfg_addr` of the matrix chosen by `cfg_mat` (0 = intra, 1 = non-intra). Levels accepted from the next edge onward use the new entry, and the other matrix is unchanged.
- R11: `in_dc_prec` has no effect on AC-path results, including the non-intra level at index 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input level is present |
| in_index | input | 6 | Position in the block, row-major |
| in_level | input | 12 | Quantized level, signed |
| in_intra | input | 1 | 1 for an intra-coded block |
| in_dc_prec | input | 2 | Intra DC precision code |
| cfg_we | input | 1 | Weighting-matrix write strobe |
| cfg_mat | input | 1 | Matrix select: 0 intra, 1 non-intra |
| cfg_addr | input | 6 | Matrix entry index |
| cfg_wdata | input | 8 | Entry value, unsigned |
| out_valid | output | 1 | Result present |
| out_index | output | 6 | Index of the result |
| out_coef | output | 12 | Reconstructed coefficient, signed |

## Verification
The checker assumes that `in_valid`, `in_index` and `in_level` are driven to known values from the first clock after reset. Its two-edge comparisons also rely on the inputs being held low during reset, so that no pre-reset value reaches the output. The bench keeps every input at zero during and right after reset. It issues matrix writes only while no level is in flight, so no result depends on whether a write and a read in the same cycle should see the old entry or the new one. Levels stay within the 12-bit signed range, and the stream is driven on falling edges.

// File: rtl/dq_pkg.sv
package dq_pkg;
    localparam int LVL_W  = 12;
    localparam int IDX_W  = 6;
    localparam int WGT_W  = 8;
    localparam int MAG_W  = LVL_W + 1;
    localparam int NCOEF  = 1 << IDX_W;
    localparam int SIDE   = 8;
    localparam int PROD_W = 32;

    typedef enum logic {
        MAT_INTRA = 1'b0,
        MAT_INTER = 1'b1
    } mat_sel_e;

    typedef struct packed {
        logic               vld;
        logic [IDX_W-1:0]   idx;
        logic               dc;
        logic               neg;
        logic [MAG_W-1:0]   mag;
        logic [1:0]         prec;
        logic [WGT_W-1:0]   wgt;
    } s1_t;

    typedef struct packed {
        logic               vld;
        logic [IDX_W-1:0]   idx;
        logic [LVL_W-1:0]   coef;
    } s2_t;

    function automatic logic [WGT_W-1:0] dflt_wgt(input logic sel, input int unsigned i);
        int unsigned r;
        int unsigned c;
        r = i / SIDE;
        c = i % SIDE;
        if (sel) dflt_wgt = WGT_W'(16 + r + c);
        else     dflt_wgt = WGT_W'(8 + 2 * (r + c));
    endfunction
endpackage

// File: rtl/dq_wstore.sv
module dq_wstore
    import dq_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic             wr_sel,
    input  logic [IDX_W-1:0] wr_addr,
    input  logic [WGT_W-1:0] wr_data,
    input  logic             rd_sel,
    input  logic [IDX_W-1:0] rd_addr,
    output logic [WGT_W-1:0] rd_wgt
);
    logic [WGT_W-1:0] mem_q [2][NCOEF];
    logic [WGT_W-1:0] mem_d [2][NCOEF];

    always_comb begin
        mem_d = mem_q;
        if (wr_en) mem_d[wr_sel][wr_addr] = wr_data;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int m = 0; m < 2; m++)
                for (int i = 0; i < NCOEF; i++)
                    mem_q[m][i] <= dflt_wgt(m[0], i);
        end else begin
            mem_q <= mem_d;
        end
    end

    assign rd_wgt = mem_q[rd_sel][rd_addr];
endmodule

// File: rtl/dq_front.sv
module dq_front
    import dq_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic [IDX_W-1:0] in_index,
    input  logic [LVL_W-1:0] in_level,
    input  logic             in_intra,
    input  logic [1:0]       in_dc_prec,
    input  logic [WGT_W-1:0] wgt,
    output s1_t              s1
);
    s1_t s1_d, s1_q;
    logic [MAG_W-1:0] abs_v;

    always_comb begin
        abs_v = in_level[LVL_W-1] ? MAG_W'(-$signed({in_level[LVL_W-1], in_level}))
                                  : MAG_W'({1'b0, in_level});
        s1_d      = '0;
        s1_d.vld  = in_valid;
        s1_d.idx  = in_index;
        s1_d.dc   = in_intra && (in_index == '0);
        s1_d.neg  = in_level[LVL_W-1];
        s1_d.prec = in_dc_prec;
        s1_d.wgt  = wgt;
        if (s1_d.dc)
            s1_d.mag = abs_v;
        else if (in_intra)
            s1_d.mag = abs_v << 1;
        else
            s1_d.mag = (abs_v << 1) + MAG_W'(abs_v != '0);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s1_q <= '0;
        else        s1_q <= s1_d;
    end

    assign s1 = s1_q;
endmodule

// File: rtl/dq_back.sv
module dq_back
    import dq_pkg::*;
#(
    parameter int QSCALE = 4,
    parameter int SHIFT  = 5
) (
    input  logic clk,
    input  logic rst_n,
    input  s1_t  s1,
    output s2_t  s2
);
    localparam logic [PROD_W-1:0] POS_LIM = PROD_W'((1 << (LVL_W - 1)) - 1);
    localparam logic [PROD_W-1:0] NEG_LIM = PROD_W'(1 << (LVL_W - 1));

    s2_t s2_d, s2_q;
    logic [PROD_W-1:0] prod;
    logic [PROD_W-1:0] clamped;
    logic [LVL_W:0]    m13;

    always_comb begin
        if (s1.dc)
            prod = PROD_W'(s1.mag) << (2'd3 - s1.prec);
        else
            prod = (PROD_W'(s1.mag) * PROD_W'(s1.wgt) * PROD_W'(QSCALE)) >> SHIFT;
        if (s1.neg) clamped = (prod > NEG_LIM) ? NEG_LIM : prod;
        else        clamped = (prod > POS_LIM) ? POS_LIM : prod;
        m13 = clamped[LVL_W:0];
        s2_d.vld  = s1.vld;
        s2_d.idx  = s1.idx;
        s2_d.coef = s1.neg ? LVL_W'(~m13 + 1'b1) : LVL_W'(m13);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s2_q <= '0;
        else        s2_q <= s2_d;
    end

    assign s2 = s2_q;
endmodule

// File: rtl/blk_dequant.sv
module blk_dequant
    import dq_pkg::*;
#(
    parameter int QSCALE = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic [IDX_W-1:0] in_index,
    input  logic [LVL_W-1:0] in_level,
    input  logic             in_intra,
    input  logic [1:0]       in_dc_prec,
    input  logic             cfg_we,
    input  logic             cfg_mat,
    input  logic [IDX_W-1:0] cfg_addr,
    input  logic [WGT_W-1:0] cfg_wdata,
    output logic             out_valid,
    output logic [IDX_W-1:0] out_index,
    output logic [LVL_W-1:0] out_coef
);
    logic [WGT_W-1:0] wgt;
    s1_t s1;
    s2_t s2;
    mat_sel_e rd_mat;

    assign rd_mat = in_intra ? MAT_INTRA : MAT_INTER;

    dq_wstore u_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (cfg_we),
        .wr_sel  (cfg_mat),
        .wr_addr (cfg_addr),
        .wr_data (cfg_wdata),
        .rd_sel  (rd_mat),
        .rd_addr (in_index),
        .rd_wgt  (wgt)
    );

    dq_front u_front (
        .clk        (clk),
        .rst_n      (rst_n),
        .in_valid   (in_valid),
        .in_index   (in_index),
        .in_level   (in_level),
        .in_intra   (in_intra),
        .in_dc_prec (in_dc_prec),
        .wgt        (wgt),
        .s1         (s1)
    );

    dq_back #(.QSCALE(QSCALE)) u_back (
        .clk   (clk),
        .rst_n (rst_n),
        .s1    (s1),
        .s2    (s2)
    );

    assign out_valid = s2.vld;
    assign out_index = s2.idx;
    assign out_coef  = s2.coef;
endmodule

// File: rtl/dq_chk.sv
module dq_chk
    import dq_pkg::*;
(
    input logic             clk,
    input logic             rst_n,
    input logic             in_valid,
    input logic [IDX_W-1:0] in_index,
    input logic [LVL_W-1:0] in_level,
    input logic             in_intra,
    input logic [1:0]       in_dc_prec,
    input logic             out_valid,
    input logic [IDX_W-1:0] out_index,
    input logic [LVL_W-1:0] out_coef
);
    logic [1:0] warm_q;
    always_ff @(posedge clk) begin
        if (!rst_n)           warm_q <= '0;
        else if (warm_q != 2'd3) warm_q <= warm_q + 2'd1;
    end

    // R2
    valid_lat_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (warm_q >= 2'd2) |-> (out_valid == $past(in_valid, 2)));

    // R2
    index_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (warm_q >= 2'd2 && $past(in_valid, 2)) |-> (out_index == $past(in_index, 2)));

    // R8
    zero_in_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (warm_q >= 2'd2 && $past(in_valid, 2) && $past(in_level, 2) == '0) |-> (out_coef == '0));

    // R6
    sign_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (warm_q >= 2'd2 && $past(in_valid, 2) && $past(in_level[LVL_W-1], 2)) |-> out_coef[LVL_W-1]);

    // R3
    dc_unit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (warm_q >= 2'd2 && $past(in_valid, 2) && $past(in_intra, 2) && $past(in_index, 2) == '0
         && $past(in_dc_prec, 2) == 2'd3) |-> (out_coef == $past(in_level, 2)));

    // R1
    rst_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (warm_q == 2'd0) |-> (!out_valid && out_coef == '0));
endmodule

bind blk_dequant dq_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .in_valid   (in_valid),
    .in_index   (in_index),
    .in_level   (in_level),
    .in_intra   (in_intra),
    .in_dc_prec (in_dc_prec),
    .out_valid  (out_valid),
    .out_index  (out_index),
    .out_coef   (out_coef)
);

// File: tb/sim_blk_dequant.sv
`timescale 1ns/1ps
module sim_blk_dequant;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic in_valid = 1'b0;
    logic [5:0] in_index = '0;
    logic [11:0] in_level = '0;
    logic in_intra = 1'b0;
    logic [1:0] in_dc_prec = '0;
    logic cfg_we = 1'b0;
    logic cfg_mat = 1'b0;
    logic [5:0] cfg_addr = '0;
    logic [7:0] cfg_wdata = '0;
    logic out_valid;
    logic [5:0] out_index;
    logic [11:0] out_coef;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    blk_dequant u0 (.*);

    typedef struct packed {
        logic               intra;
        logic [1:0]         prec;
        logic [5:0]         idx;
        logic signed [11:0] lvl;
        logic signed [11:0] exp;
    } vec_t;

    localparam int NV = 20;
    localparam vec_t VEC [NV] = '{
        '{1'b1, 2'd0, 6'd0,  12'sd10,    12'sd80},     // R3 prec 0
        '{1'b1, 2'd1, 6'd0,  -12'sd7,    -12'sd28},    // R3 prec 1
        '{1'b1, 2'd2, 6'd0,  12'sd100,   12'sd200},    // R3 prec 2
        '{1'b1, 2'd3, 6'd0,  -12'sd2048, -12'sd2048},  // R3 prec 3
        '{1'b1, 2'd0, 6'd0,  12'sd300,   12'sd2047},   // R7 high
        '{1'b1, 2'd0, 6'd0,  -12'sd300,  -12'sd2048},  // R7 low
        '{1'b1, 2'd0, 6'd1,  12'sd5,     12'sd12},     // R4 W=10
        '{1'b1, 2'd0, 6'd1,  -12'sd5,    -12'sd12},    // R6
        '{1'b1, 2'd0, 6'd63, 12'sd3,     12'sd27},     // R9 W=36
        '{1'b0, 2'd0, 6'd0,  12'sd1,     12'sd6},      // R5 W=16
        '{1'b0, 2'd0, 6'd0,  -12'sd1,    -12'sd6},     // R5
        '{1'b0, 2'd0, 6'd9,  12'sd2,     12'sd11},     // R9 W=18
        '{1'b0, 2'd0, 6'd9,  -12'sd2,    -12'sd11},    // R6
        '{1'b0, 2'd0, 6'd63, 12'sd1000,  12'sd2047},   // R7
        '{1'b1, 2'd0, 6'd0,  12'sd0,     12'sd0},      // R8
        '{1'b0, 2'd0, 6'd5,  12'sd0,     12'sd0},      // R8
        '{1'b1, 2'd3, 6'd8,  12'sd7,     12'sd17},     // R11
        '{1'b1, 2'd0, 6'd8,  12'sd7,     12'sd17},     // R11
        '{1'b0, 2'd3, 6'd0,  12'sd4,     12'sd18},     // R11 non-intra DC
        '{1'b1, 2'd0, 6'd63, -12'sd2048, -12'sd2048}   // R7
    };

    function automatic string vec_req(input int i);
        case (i)
            0, 1, 2, 3:  vec_req = "R3";
            4, 5, 13, 19: vec_req = "R7";
            6:           vec_req = "R4";
            7, 12:       vec_req = "R6";
            8, 11:       vec_req = "R9";
            9, 10:       vec_req = "R5";
            14, 15:      vec_req = "R8";
            default:     vec_req = "R11";
        endcase
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, $signed(act), $signed(exp));
        end
    endtask

    task automatic drive(input logic v, input logic intra, input logic [1:0] prec,
                         input logic [5:0] idx, input logic [11:0] lvl);
        in_valid = v; in_intra = intra; in_dc_prec = prec; in_index = idx; in_level = lvl;
    endtask

    task automatic single(input logic intra, input logic [1:0] prec, input logic [5:0] idx,
                          input logic [11:0] lvl, output logic [11:0] coef);
        @(negedge clk); drive(1'b1, intra, prec, idx, lvl);
        @(negedge clk); drive(1'b0, 1'b0, 2'd0, 6'd0, 12'd0);
        @(negedge clk); coef = out_coef;
    endtask

    task automatic cfg_write(input logic mat, input logic [5:0] addr, input logic [7:0] d);
        @(negedge clk); cfg_we = 1'b1; cfg_mat = mat; cfg_addr = addr; cfg_wdata = d;
        @(negedge clk); cfg_we = 1'b0;
    endtask

    initial begin
        int cyc = 0;
        while (!done && cyc < 20000) begin
            @(posedge clk);
            cyc++;
        end
        if (!done) begin
            checks++; failures++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
            $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        logic [11:0] c;
        repeat (3) @(negedge clk);
        // R1: state during reset
        check("R1 valid in reset", 32'(out_valid), 32'd0);
        check("R1 coef in reset", 32'(out_coef), 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 valid after reset", 32'(out_valid), 32'd0);

        // Vector stream, one per clock
        for (int i = 0; i < NV + 2; i++) begin
            @(negedge clk);
            if (i >= 2) begin
                check({vec_req(i - 2), " valid"}, 32'(out_valid), 32'd1);
                check("R2 index", 32'(out_index), 32'(VEC[i-2].idx));
                check(vec_req(i - 2), 32'($signed(out_coef)), 32'(VEC[i-2].exp));
            end
            if (i < NV) drive(1'b1, VEC[i].intra, VEC[i].prec, VEC[i].idx, VEC[i].lvl);
            else        drive(1'b0, 1'b0, 2'd0, 6'd0, 12'd0);
        end

        // R2: isolated level timing
        @(negedge clk); drive(1'b1, 1'b0, 2'd0, 6'd33, 12'd1);
        @(negedge clk); drive(1'b0, 1'b0, 2'd0, 6'd0, 12'd0);
        check("R2 not yet", 32'(out_valid), 32'd0);
        @(negedge clk);
        check("R2 valid", 32'(out_valid), 32'd1);
        check("R2 index", 32'(out_index), 32'd33);
        @(negedge clk);
        check("R2 drop", 32'(out_valid), 32'd0);

        // R10: custom entries
        cfg_write(1'b0, 6'd1, 8'd100);
        single(1'b1, 2'd0, 6'd1, 12'd5, c);
        check("R10 intra custom", 32'($signed(c)), 32'd125);
        single(1'b0, 2'd0, 6'd1, 12'd4, c);
        check("R10 other matrix kept", 32'($signed(c)), 32'd19);
        cfg_write(1'b1, 6'd0, 8'd255);
        single(1'b0, 2'd0, 6'd0, -12'sd3, c);
        check("R10 inter custom", 32'($signed(c)), -32'sd223);
        single(1'b1, 2'd0, 6'd0, 12'd9, c);
        check("R10 intra dc untouched", 32'($signed(c)), 32'd72);

        // R1: reset restores defaults (R9)
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); rst_n = 1'b1;
        single(1'b1, 2'd0, 6'd1, 12'd5, c);
        check("R9 default restored", 32'($signed(c)), 32'd12);

        done = 1'b1;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule